// File: doc/BRIEF.md
# Palette Port Access Steering Unit

This block sits between the host I/O decoder and the colour palette. It steers each host access to the four palette ports (offsets 0 to 3 of the palette window) to an on-chip lookup table (LUT), to an external palette DAC, or to both. The choice depends on a read-routing configuration bit, on whether the CRT path is enabled, and on the current power state. It drives one shared palette address and write-data bus, the LUT read and write enables, and the active-low DAC read and write strobes. It also selects which source supplies host read data.

Power state codes are 0 (active), 1 and 2 (light power save) and 3 or higher (deep power save). In deep power save neither palette target can be reached. A host write made in that state is held in a single address/data register. Each later deep-state write overwrites it, and the held write is replayed once the block returns to a reachable state. The block also drives a DAC sleep output and an active-low DAC current-reference enable. Both follow the power state.

All outputs are registered. A host request presented before a rising clock edge shows up on the outputs just after that edge.

Top module: `pal_steer`

## Requirements
- R1: In power state 0 to 2, a read of port 0, 2 or 3 while cfgExtRead=1 pulses dacRdN low and keeps lutRdEn low. hostRData then returns dacRData.
- R2: In power state 0 to 2, a read of port 0, 2 or 3 while cfgExtRead=0 pulses lutRdEn, keeps dacRdN high and returns lutRData.
- R3: A read of port 1, the status port, is always served by the LUT (lutRdEn, lutRData), whatever cfgExtRead holds.
- R4: In power state 0 to 2, a host write pulses lutWrEn with the port on palAddr and the data on palWData. dacWrN is low in the same cycle only when crtEnable=1.
- R5: In power state 3 or higher, no host access raises lutWrEn or lutRdEn. A write is stored, and a later write in that state replaces the stored one.
- R6: On the first clock in power state 0 to 2 with a stored write and no host read, the stored write is issued to the LUT (and to the DAC when crtEnable=1), exactly once.
- R7: A host read in the same cycle as a pending replay goes first. The replay follows on the next free cycle.
- R8: A host write in the same cycle as a pending replay is issued one cycle after the replay, so write order is kept.
- R9: In power state 3 or higher, dacWrN and dacRdN are both held at the level of cfgParkHigh (1 means inactive high, 0 means parked low).
- R10: dacSleep equals cfgSleep in power state 0 with crtEnable=1, and is 1 in every other case, including reset.
- R11: irefEnN is 1 in power state 3 or higher and during reset, and 0 in power states 0 to 2.
- R12: Each accepted access yields a strobe lasting exactly one clock, and LUT read and write enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | One-cycle host access request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 2 | Palette port (0..3; 1 = status) |
| hostWData | input | 8 | Host write data |
| hostRData | output | 8 | Read data from the selected source |
| cfgExtRead | input | 1 | Route data-port reads to the DAC |
| cfgParkHigh | input | 1 | DAC strobe level in deep power save |
| cfgSleep | input | 1 | DAC sleep level when active with CRT |
| crtEnable | input | 1 | CRT path enabled |
| powerMode | input | 3 | Power state code |
| lutRData | input | 8 | LUT read data |
| dacRData | input | 8 | DAC read data |
| lutWrEn | output | 1 | LUT write enable |
| lutRdEn | output | 1 | LUT read enable |
| dacWrN | output | 1 | DAC write strobe, active low |
| dacRdN | output | 1 | DAC read strobe, active low |
| palAddr | output | 2 | Shared palette port address |
| palWData | output | 8 | Shared palette write data |
| dacSleep | output | 1 | DAC sleep request |
| irefEnN | output | 1 | DAC current-reference enable, active low |

## Verification
The assertions assume that hostValid is a single-cycle pulse carrying a well-formed read or write, and that the configuration and power inputs are stable while the clock edge samples them. The stimulus changes every input only at the falling edge and raises hostValid for one cycle per access. It moves between power states only across idle or single-access cycles, which gives the replay, read-priority and write-collision orderings their intended cycle alignment.

// File: rtl/pal_steer_pkg.sv
package pal_steer_pkg;

  // Per-cycle decisions passed from control to datapath
  typedef struct packed {
    logic lutRd;      // LUT read this cycle
    logic dacRd;      // external DAC read this cycle
    logic hostWr;     // host write issued directly
    logic replay;     // stored write issued
    logic capture;    // load holding register from host
    logic clearPend;  // retire holding register
    logic crtWr;      // mirror writes to the DAC
    logic park;       // deep power save: strobes parked
    logic parkLevel;  // parked strobe level
  } steerCtl_t;

endpackage

// File: rtl/pal_steer_ctrl.sv
module pal_steer_ctrl
  import pal_steer_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int MODE_W      = 3,
  parameter int STATUS_PORT = 1,
  parameter int DEEP_FIRST  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              cfgExtRead,
  input  logic              cfgParkHigh,
  input  logic              cfgSleep,
  input  logic              crtEnable,
  input  logic [MODE_W-1:0] powerMode,
  input  logic              pendValid,
  output steerCtl_t         ctl,
  output logic              dacSleep,
  output logic              irefEnN
);

  localparam logic [MODE_W-1:0] DEEP_CODE   = MODE_W'(DEEP_FIRST);
  localparam logic [ADDR_W-1:0] STATUS_CODE = ADDR_W'(STATUS_PORT);

  logic deep, isRead, isWrite, statusHit, replayGo;

  always_comb begin
    deep      = (powerMode >= DEEP_CODE);
    isRead    = hostValid && !hostWrite;
    isWrite   = hostValid && hostWrite;
    statusHit = (hostAddr == STATUS_CODE);
    replayGo  = !deep && pendValid && !isRead;

    ctl           = '0;
    ctl.park      = deep;
    ctl.parkLevel = cfgParkHigh;
    ctl.crtWr     = crtEnable;
    ctl.replay    = replayGo;
    ctl.lutRd     = !deep && isRead && (statusHit || !cfgExtRead);
    ctl.dacRd     = !deep && isRead && !statusHit && cfgExtRead;
    ctl.hostWr    = !deep && isWrite && !replayGo;
    ctl.capture   = isWrite && (deep || replayGo);
    ctl.clearPend = replayGo && !isWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacSleep <= 1'b1;
      irefEnN  <= 1'b1;
    end else begin
      dacSleep <= (powerMode == '0 && crtEnable) ? cfgSleep : 1'b1;
      irefEnN  <= deep;
    end
  end

  p_read_beats_replay_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && !hostWrite) |-> !ctl.replay);

  p_iref_off_deep_r11 : assert property (@(posedge clk) disable iff (!rstN)
    (powerMode >= DEEP_CODE) |=> irefEnN);

  p_iref_on_normal_r11 : assert property (@(posedge clk) disable iff (!rstN)
    (powerMode < DEEP_CODE) |=> !irefEnN);

  p_sleep_forced_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (powerMode != '0 || !crtEnable) |=> dacSleep);

endmodule

// File: rtl/pal_steer_dp.sv
module pal_steer_dp
  import pal_steer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  steerCtl_t         ctl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWData,
  input  logic [DATA_W-1:0] lutRData,
  input  logic [DATA_W-1:0] dacRData,
  output logic              pendValid,
  output logic              lutWrEn,
  output logic              lutRdEn,
  output logic              dacWrN,
  output logic              dacRdN,
  output logic [ADDR_W-1:0] palAddr,
  output logic [DATA_W-1:0] palWData,
  output logic [DATA_W-1:0] hostRData
);

  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;
  logic              rdSelExt;
  logic              doWr;

  assign doWr = ctl.replay || ctl.hostWr;

  // Single-entry holding register for deferred writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else if (ctl.capture) begin
      pendValid <= 1'b1;
      pendAddr  <= hostAddr;
      pendData  <= hostWData;
    end else if (ctl.clearPend) begin
      pendValid <= 1'b0;
    end
  end

  // Registered strobes and shared bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lutWrEn  <= 1'b0;
      lutRdEn  <= 1'b0;
      dacWrN   <= 1'b1;
      dacRdN   <= 1'b1;
      rdSelExt <= 1'b0;
      palAddr  <= '0;
      palWData <= '0;
    end else begin
      lutWrEn  <= doWr;
      lutRdEn  <= ctl.lutRd;
      dacWrN   <= ctl.park ? ctl.parkLevel : !(doWr && ctl.crtWr);
      dacRdN   <= ctl.park ? ctl.parkLevel : !ctl.dacRd;
      rdSelExt <= ctl.dacRd;
      palAddr  <= ctl.replay ? pendAddr : hostAddr;
      palWData <= ctl.replay ? pendData : hostWData;
    end
  end

  assign hostRData = rdSelExt ? dacRData : lutRData;

  p_deep_silent_r5 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.park |=> (!lutWrEn && !lutRdEn));

  p_replay_payload_r6 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.replay |=> (lutWrEn && palAddr == $past(pendAddr) && palWData == $past(pendData)));

  p_pend_retired_r6 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearPend |=> !pendValid);

  p_park_level_r9 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.park |=> (dacWrN == $past(ctl.parkLevel) && dacRdN == $past(ctl.parkLevel)));

  p_lut_exclusive_r12 : assert property (@(posedge clk) disable iff (!rstN)
    !(lutWrEn && lutRdEn));

endmodule

// File: rtl/pal_steer.sv
module pal_steer
  import pal_steer_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int MODE_W      = 3,
  parameter int STATUS_PORT = 1,
  parameter int DEEP_FIRST  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWData,
  output logic [DATA_W-1:0] hostRData,
  input  logic              cfgExtRead,
  input  logic              cfgParkHigh,
  input  logic              cfgSleep,
  input  logic              crtEnable,
  input  logic [MODE_W-1:0] powerMode,
  input  logic [DATA_W-1:0] lutRData,
  input  logic [DATA_W-1:0] dacRData,
  output logic              lutWrEn,
  output logic              lutRdEn,
  output logic              dacWrN,
  output logic              dacRdN,
  output logic [ADDR_W-1:0] palAddr,
  output logic [DATA_W-1:0] palWData,
  output logic              dacSleep,
  output logic              irefEnN
);

  steerCtl_t ctl;
  logic      pendValid;

  pal_steer_ctrl #(
    .ADDR_W(ADDR_W), .MODE_W(MODE_W),
    .STATUS_PORT(STATUS_PORT), .DEEP_FIRST(DEEP_FIRST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostWrite(hostWrite), .hostAddr(hostAddr),
    .cfgExtRead(cfgExtRead), .cfgParkHigh(cfgParkHigh), .cfgSleep(cfgSleep),
    .crtEnable(crtEnable), .powerMode(powerMode),
    .pendValid(pendValid), .ctl(ctl),
    .dacSleep(dacSleep), .irefEnN(irefEnN)
  );

  pal_steer_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hostAddr(hostAddr), .hostWData(hostWData),
    .lutRData(lutRData), .dacRData(dacRData),
    .pendValid(pendValid),
    .lutWrEn(lutWrEn), .lutRdEn(lutRdEn),
    .dacWrN(dacWrN), .dacRdN(dacRdN),
    .palAddr(palAddr), .palWData(palWData),
    .hostRData(hostRData)
  );

endmodule

// File: tb/pal_steer_tb.sv
`timescale 1ns/1ps
module pal_steer_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostValid = 1'b0, hostWrite = 1'b0;
  logic [1:0] hostAddr = '0;
  logic [7:0] hostWData = '0;
  logic [7:0] hostRData;
  logic cfgExtRead = 1'b1, cfgParkHigh = 1'b1, cfgSleep = 1'b0, crtEnable = 1'b1;
  logic [2:0] powerMode = '0;
  logic [7:0] lutRData = 8'h11, dacRData = 8'h22;
  logic lutWrEn, lutRdEn, dacWrN, dacRdN, dacSleep, irefEnN;
  logic [1:0] palAddr;
  logic [7:0] palWData;

  int checks = 0, errors = 0;
  bit finished = 0;

  // next-cycle configuration, applied by the driver at the falling edge
  logic nExt = 1'b1, nPark = 1'b1, nSleep = 1'b0, nCrt = 1'b1;
  logic [2:0] nMode = '0;

  typedef struct {
    logic lw, lr, dw, dr, sl, ir;
    logic [1:0] a;
    logic [7:0] d;
    logic [7:0] rd;   // 0 = do not check read data
    string tag;
  } exp_t;

  exp_t q[$];

  always #2 clk = ~clk;

  pal_steer u_dut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWData(hostWData), .hostRData(hostRData),
    .cfgExtRead(cfgExtRead), .cfgParkHigh(cfgParkHigh), .cfgSleep(cfgSleep),
    .crtEnable(crtEnable), .powerMode(powerMode),
    .lutRData(lutRData), .dacRData(dacRData),
    .lutWrEn(lutWrEn), .lutRdEn(lutRdEn), .dacWrN(dacWrN), .dacRdN(dacRdN),
    .palAddr(palAddr), .palWData(palWData),
    .dacSleep(dacSleep), .irefEnN(irefEnN)
  );

  function automatic exp_t mk(logic lw, logic lr, logic dw, logic dr,
                              logic [1:0] a, logic [7:0] d, logic [7:0] rd,
                              logic sl, logic ir, string tag);
    exp_t e;
    e.lw = lw; e.lr = lr; e.dw = dw; e.dr = dr; e.a = a; e.d = d;
    e.rd = rd; e.sl = sl; e.ir = ir; e.tag = tag;
    return e;
  endfunction

  task automatic step(input logic v, input logic w, input logic [1:0] a,
                      input logic [7:0] d, input exp_t e);
    @(negedge clk);
    cfgExtRead = nExt; cfgParkHigh = nPark; cfgSleep = nSleep;
    crtEnable = nCrt; powerMode = nMode;
    hostValid = v; hostWrite = w; hostAddr = a; hostWData = d;
    q.push_back(e);
  endtask

  // monitor: one expected item per rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        checks++;
        bad = (lutWrEn != e.lw) || (lutRdEn != e.lr) || (dacWrN != e.dw) ||
              (dacRdN != e.dr) || (dacSleep != e.sl) || (irefEnN != e.ir) ||
              (e.lw && (palAddr != e.a || palWData != e.d)) ||
              (e.rd != 8'h00 && hostRData != e.rd);
        if (bad) begin
          errors++;
          $display("FAIL %s: actual lw=%b lr=%b wN=%b rN=%b sl=%b ir=%b a=%0d d=%h rd=%h expected lw=%b lr=%b wN=%b rN=%b sl=%b ir=%b a=%0d d=%h rd=%h",
            e.tag, lutWrEn, lutRdEn, dacWrN, dacRdN, dacSleep, irefEnN, palAddr, palWData, hostRData,
            e.lw, e.lr, e.dw, e.dr, e.sl, e.ir, e.a, e.d, e.rd);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R10, R11)
    checks++;
    if (lutWrEn || lutRdEn || !dacWrN || !dacRdN || !dacSleep || !irefEnN) begin
      errors++;
      $display("FAIL R11 reset: actual lw=%b lr=%b wN=%b rN=%b sl=%b ir=%b expected 0 0 1 1 1 1",
               lutWrEn, lutRdEn, dacWrN, dacRdN, dacSleep, irefEnN);
    end
    rstN = 1'b1;

    step(0, 0, 0, 8'h00, mk(0,0,1,1, 0,8'h00,8'h00, 0,0, "R10 active idle"));
    step(1, 0, 0, 8'h00, mk(0,0,1,0, 0,8'h00,8'h22, 0,0, "R1 ext read"));
    step(1, 0, 1, 8'h00, mk(0,1,1,1, 0,8'h00,8'h11, 0,0, "R3 status read"));
    nExt = 1'b0;
    step(1, 0, 3, 8'h00, mk(0,1,1,1, 0,8'h00,8'h11, 0,0, "R2 lut read"));
    step(1, 1, 2, 8'hA5, mk(1,0,0,1, 2,8'hA5,8'h00, 0,0, "R4 dual write"));
    nCrt = 1'b0;
    step(1, 1, 3, 8'h3C, mk(1,0,1,1, 3,8'h3C,8'h00, 1,0, "R4 lut-only write"));
    nCrt = 1'b1; nMode = 3'd1;
    step(1, 1, 0, 8'h5A, mk(1,0,0,1, 0,8'h5A,8'h00, 1,0, "R4 mode1 write"));
    nMode = 3'd3;
    step(1, 1, 1, 8'h77, mk(0,0,1,1, 0,8'h00,8'h00, 1,1, "R5 deep write held"));
    nPark = 1'b0;
    step(1, 1, 2, 8'h88, mk(0,0,0,0, 0,8'h00,8'h00, 1,1, "R9 park low overwrite"));
    nMode = 3'd4;
    step(1, 0, 0, 8'h00, mk(0,0,0,0, 0,8'h00,8'h00, 1,1, "R5 deep read blocked"));
    nPark = 1'b1;
    step(0, 0, 0, 8'h00, mk(0,0,1,1, 0,8'h00,8'h00, 1,1, "R9 park high"));
    nMode = 3'd0;
    step(0, 0, 0, 8'h00, mk(1,0,0,1, 2,8'h88,8'h00, 0,0, "R6 replay last write"));
    step(0, 0, 0, 8'h00, mk(0,0,1,1, 0,8'h00,8'h00, 0,0, "R12 replay once"));
    nMode = 3'd3;
    step(1, 1, 3, 8'h99, mk(0,0,1,1, 0,8'h00,8'h00, 1,1, "R5 deep write"));
    nMode = 3'd0;
    step(1, 0, 1, 8'h00, mk(0,1,1,1, 0,8'h00,8'h11, 0,0, "R7 read first"));
    step(0, 0, 0, 8'h00, mk(1,0,0,1, 3,8'h99,8'h00, 0,0, "R7 replay after read"));
    nMode = 3'd4;
    step(1, 1, 0, 8'h10, mk(0,0,1,1, 0,8'h00,8'h00, 1,1, "R5 deep write"));
    nMode = 3'd2;
    step(1, 1, 1, 8'h20, mk(1,0,0,1, 0,8'h10,8'h00, 1,0, "R8 replay before host write"));
    step(0, 0, 0, 8'h00, mk(1,0,0,1, 1,8'h20,8'h00, 1,0, "R8 host write follows"));
    step(0, 0, 0, 8'h00, mk(0,0,1,1, 0,8'h00,8'h00, 1,0, "R12 no extra strobe"));

    wait (q.size() == 0);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule